// File: doc/BRIEF.md
# Four-Way Toom-Cook Interpolation and Recomposition Engine

This block takes the seven point-wise sub-products of a four-way Toom-Cook polynomial multiplication and turns them into the full product polynomial. The sub-products come from the points infinity, 2, 1, -1, 1/2, -1/2 and 0. One beat carries the coefficient of the same index from all seven sub-products. For each beat the block runs the fixed sixteen-step interpolation chain. It works modulo 2^(COEF_BITS+3), so three guard bits keep the shifts of the exact divisions correct. Each result is then reduced to the coefficient modulus and added into an on-chip product store.

Each operand has 4*SEG_LEN coefficients. A sub-product therefore has 2*SEG_LEN-1 coefficients, and a frame is that many input beats. Interpolated output k is the coefficient of y^k, with y = x^SEG_LEN, so it lands at offset SEG_LEN*k in the store. After the last beat of a frame, the block streams out all 8*SEG_LEN-1 product coefficients, lowest index first, and clears each entry as it leaves. The next frame then starts from an empty store.

Both sides use valid/ready. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. An output coefficient is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented coefficient holds. The two phases never overlap, so the input side is stalled for the whole drain.

Top module: `tc4_interp_top`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Exactly one of `in_ready` and `out_valid` is high in every cycle. `in_ready` falls in the cycle after the last input beat of a frame is accepted.
- R3: Input lane p of `in_data` (bits p*W and up, where W = COEF_BITS+3) carries the sub-product at the p-th point of the order infinity, 2, 1, -1, 1/2, -1/2, 0. The two half-points are pre-scaled by 8 per operand, and all values are modulo 2^W.
- R4: The output stream is the linear product of the two operands modulo 2^COEF_BITS, coefficient 0 first, 8*SEG_LEN-1 coefficients per frame.
- R5: `out_valid` rises in the cycle after the (2*SEG_LEN-1)-th accepted input beat. It stays high until the final coefficient is consumed.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R7: `out_last` is high only together with the final coefficient (index 8*SEG_LEN-2) of a frame.
- R8: In the cycle after the final coefficient is consumed, `in_ready` is 1 and `out_valid` is 0. The next frame's result does not depend on earlier frames.
- R9: With COEF_BITS = 10 (13-bit working width), the output is the product modulo 2^10.
- R10: An input beat offered while `in_ready` is low is not taken and does not change the result.
- R11: Idle cycles between input beats do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block accepts an input beat |
| in_data | input | 7*(COEF_BITS+3) | Seven sub-product coefficients of one index, lane p as in R3 |
| out_valid | output | 1 | Product coefficient presented |
| out_ready | input | 1 | Consumer takes the presented coefficient |
| out_data | output | COEF_BITS | Product coefficient modulo 2^COEF_BITS |
| out_last | output | 1 | Final coefficient of the frame |

## Verification
Interpolation and accumulation happen on the same edge that accepts a beat. The first product coefficient is therefore due one cycle after the last input beat is accepted. Each later coefficient is due one cycle after the previous one is consumed. The bench drives inputs and samples outputs on the falling edge. It compares the coefficient presented at the falling edge before each consuming rising edge against a schoolbook product computed in the bench. It checks the phase flags at the falling edge right after the last input beat and right after the final pop. During stalls it compares the held value across several falling edges.

// File: rtl/tc4_pkg.sv
package tc4_pkg;

  localparam int NUM_PTS = 7;
  localparam int GUARD_BITS = 3;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;

  // Inverse of an odd value modulo 2^32 by Newton iteration; each round
  // doubles the number of correct low bits (3 -> 6 -> 12 -> 24 -> 48).
  function automatic logic [31:0] odd_inverse(input logic [31:0] a);
    logic [31:0] x;
    x = a;
    for (int i = 0; i < 5; i++) begin
      x = x * (32'd2 - a * x);
    end
    return x;
  endfunction

endpackage

// File: rtl/tc4_interp_core.sv
module tc4_interp_core
  import tc4_pkg::*;
#(
  parameter int COEF_BITS = 13,
  parameter int WORK_BITS = 16
) (
  input  logic [NUM_PTS*WORK_BITS-1:0] pts,
  output logic [COEF_BITS-1:0]         coef [NUM_PTS]
);

  localparam logic [WORK_BITS-1:0] INV3  = WORK_BITS'(odd_inverse(32'd3));
  localparam logic [WORK_BITS-1:0] INV9  = WORK_BITS'(odd_inverse(32'd9));
  localparam logic [WORK_BITS-1:0] INV15 = WORK_BITS'(odd_inverse(32'd15));
  localparam logic [WORK_BITS-1:0] K30   = WORK_BITS'(30);
  localparam logic [WORK_BITS-1:0] K45   = WORK_BITS'(45);
  localparam logic [WORK_BITS-1:0] K65   = WORK_BITS'(65);

  logic [WORK_BITS-1:0] p_inf, p_two, p_one, p_mone, p_half, p_mhalf, p_zero;
  logic [WORK_BITS-1:0] t_div;

  always_comb begin
    p_inf   = pts[0*WORK_BITS +: WORK_BITS];
    p_two   = pts[1*WORK_BITS +: WORK_BITS];
    p_one   = pts[2*WORK_BITS +: WORK_BITS];
    p_mone  = pts[3*WORK_BITS +: WORK_BITS];
    p_half  = pts[4*WORK_BITS +: WORK_BITS];
    p_mhalf = pts[5*WORK_BITS +: WORK_BITS];
    p_zero  = pts[6*WORK_BITS +: WORK_BITS];

    p_two   = p_two + p_half;
    p_mhalf = p_mhalf - p_half;
    t_div   = p_mone - p_one;
    p_mone  = t_div >> 1;
    p_half  = p_half - p_inf - (p_zero << 6);
    p_one   = p_one + p_mone;
    p_half  = (p_half << 1) + p_mhalf;
    p_two   = p_two - K65 * p_one;
    p_one   = p_one - p_zero - p_inf;
    p_two   = p_two + K45 * p_one;
    t_div   = (p_half - (p_one << 3)) * INV3;
    p_half  = t_div >> 3;
    p_mhalf = p_mhalf + p_two;
    t_div   = (p_two + (p_mone << 4)) * INV9;
    p_two   = t_div >> 1;
    p_one   = p_one - p_half;
    p_mone  = '0 - (p_mone + p_two);
    t_div   = (K30 * p_two - p_mhalf) * INV15;
    p_mhalf = t_div >> 2;
    p_two   = p_two - p_mhalf;

    coef[0] = p_zero[COEF_BITS-1:0];
    coef[1] = p_mhalf[COEF_BITS-1:0];
    coef[2] = p_half[COEF_BITS-1:0];
    coef[3] = p_mone[COEF_BITS-1:0];
    coef[4] = p_one[COEF_BITS-1:0];
    coef[5] = p_two[COEF_BITS-1:0];
    coef[6] = p_inf[COEF_BITS-1:0];
  end

endmodule

// File: rtl/tc4_beat_ctrl.sv
module tc4_beat_ctrl
  import tc4_pkg::*;
#(
  parameter int PROD_LEN = 127,
  parameter int OUT_LEN  = 511,
  parameter int IDX_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             take_beat,
  output logic             pop_coef,
  output logic [IDX_W-1:0] beat_idx,
  output logic [IDX_W-1:0] rd_idx
);

  localparam logic [IDX_W-1:0] BEAT_MAX = IDX_W'(PROD_LEN - 1);
  localparam logic [IDX_W-1:0] RD_MAX   = IDX_W'(OUT_LEN - 1);

  phase_e phase;

  assign in_ready  = (phase == PH_FILL);
  assign out_valid = (phase == PH_DRAIN);
  assign out_last  = out_valid && (rd_idx == RD_MAX);
  assign take_beat = in_valid && in_ready;
  assign pop_coef  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_FILL;
      beat_idx <= '0;
      rd_idx   <= '0;
    end else begin
      if (take_beat) begin
        if (beat_idx == BEAT_MAX) begin
          beat_idx <= '0;
          phase    <= PH_DRAIN;
        end else begin
          beat_idx <= beat_idx + 1'b1;
        end
      end
      if (pop_coef) begin
        if (rd_idx == RD_MAX) begin
          rd_idx <= '0;
          phase  <= PH_FILL;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tc4_recomp_acc.sv
module tc4_recomp_acc
  import tc4_pkg::*;
#(
  parameter int COEF_BITS = 13,
  parameter int SEG_LEN   = 64,
  parameter int IDX_W     = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 add_en,
  input  logic [IDX_W-1:0]     add_idx,
  input  logic [COEF_BITS-1:0] coef [NUM_PTS],
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [COEF_BITS-1:0] rd_data
);

  localparam int OUT_LEN = 8 * SEG_LEN - 1;

  logic [COEF_BITS-1:0] store [OUT_LEN];
  logic [COEF_BITS-1:0] nxt   [OUT_LEN];

  always_comb begin
    for (int e = 0; e < OUT_LEN; e++) begin
      nxt[e] = store[e];
      for (int k = 0; k < NUM_PTS; k++) begin
        if (add_en && (int'(add_idx) + SEG_LEN * k == e)) begin
          nxt[e] = nxt[e] + coef[k];
        end
      end
      if (clr_en && (int'(clr_idx) == e)) begin
        nxt[e] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < OUT_LEN; e++) begin
        store[e] <= '0;
      end
    end else begin
      for (int e = 0; e < OUT_LEN; e++) begin
        store[e] <= nxt[e];
      end
    end
  end

  assign rd_data = store[rd_idx];

endmodule

// File: rtl/tc4_interp_top.sv
module tc4_interp_top
  import tc4_pkg::*;
#(
  parameter int COEF_BITS = 13,
  parameter int SEG_LEN   = 64
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  output logic                                      in_ready,
  input  logic [NUM_PTS*(COEF_BITS+GUARD_BITS)-1:0] in_data,
  output logic                                      out_valid,
  input  logic                                      out_ready,
  output logic [COEF_BITS-1:0]                      out_data,
  output logic                                      out_last
);

  localparam int WORK_BITS = COEF_BITS + GUARD_BITS;
  localparam int PROD_LEN  = 2 * SEG_LEN - 1;
  localparam int OUT_LEN   = 8 * SEG_LEN - 1;
  localparam int IDX_W     = $clog2(OUT_LEN + 1);

  logic                 take_beat;
  logic                 pop_coef;
  logic [IDX_W-1:0]     beat_idx;
  logic [IDX_W-1:0]     rd_idx;
  logic [COEF_BITS-1:0] coef [NUM_PTS];

  tc4_beat_ctrl #(
    .PROD_LEN(PROD_LEN),
    .OUT_LEN (OUT_LEN),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_last (out_last),
    .take_beat(take_beat),
    .pop_coef (pop_coef),
    .beat_idx (beat_idx),
    .rd_idx   (rd_idx)
  );

  tc4_interp_core #(
    .COEF_BITS(COEF_BITS),
    .WORK_BITS(WORK_BITS)
  ) u_core (
    .pts (in_data),
    .coef(coef)
  );

  tc4_recomp_acc #(
    .COEF_BITS(COEF_BITS),
    .SEG_LEN  (SEG_LEN),
    .IDX_W    (IDX_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .add_en (take_beat),
    .add_idx(beat_idx),
    .coef   (coef),
    .clr_en (pop_coef),
    .clr_idx(rd_idx),
    .rd_idx (rd_idx),
    .rd_data(out_data)
  );

endmodule

// File: rtl/tc4_interp_chk.sv
module tc4_interp_chk #(
  parameter int COEF_BITS = 13,
  parameter int SEG_LEN   = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [COEF_BITS-1:0] out_data,
  input logic                 out_last
);

  localparam int PROD_LEN = 2 * SEG_LEN - 1;

  logic [15:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;
    end else if (out_last && out_ready) begin
      seen <= '0;
    end else if (in_valid && in_ready) begin
      seen <= seen + 16'd1;
    end
  end

  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != out_valid);

  // R5
  beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (seen == 16'(PROD_LEN)));

  // R5
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_last && out_ready)) |=> out_valid);

  // R6
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8
  frame_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_last && out_ready) |=> (in_ready && !out_valid));

endmodule

bind tc4_interp_top tc4_interp_chk #(
  .COEF_BITS(COEF_BITS),
  .SEG_LEN  (SEG_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last)
);

// File: tb/tb_tc4_interp_top.sv
module tb_tc4_interp_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEG  = 4;
  localparam int PL   = 2 * SEG - 1;
  localparam int OL   = 8 * SEG - 1;
  localparam int NC   = 4 * SEG;
  localparam int CB   = 13;
  localparam int CB_B = 10;
  localparam int WB   = CB + 3;
  localparam int WB_B = CB_B + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            in_valid;
  logic            in_ready, in_ready_b;
  logic [7*WB-1:0] in_data;
  logic [7*WB_B-1:0] in_data_b;
  logic            out_valid, out_valid_b;
  logic            out_ready;
  logic [CB-1:0]   out_data;
  logic [CB_B-1:0] out_data_b;
  logic            out_last, out_last_b;

  tc4_interp_top #(.COEF_BITS(CB), .SEG_LEN(SEG)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  tc4_interp_top #(.COEF_BITS(CB_B), .SEG_LEN(SEG)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_data(in_data_b), .out_valid(out_valid_b), .out_ready(out_ready),
    .out_data(out_data_b), .out_last(out_last_b)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int a [NC];
  int b [NC];
  longint sp [7][PL];
  longint expv [OL];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint ev(input bit use_b, input int p, input int i);
    longint x0, x1, x2, x3;
    x0 = use_b ? b[i] : a[i];
    x1 = use_b ? b[SEG + i] : a[SEG + i];
    x2 = use_b ? b[2*SEG + i] : a[2*SEG + i];
    x3 = use_b ? b[3*SEG + i] : a[3*SEG + i];
    case (p)
      0: return x3;
      1: return x0 + 2*x1 + 4*x2 + 8*x3;
      2: return x0 + x1 + x2 + x3;
      3: return x0 - x1 + x2 - x3;
      4: return 8*x0 + 4*x1 + 2*x2 + x3;
      5: return 8*x0 - 4*x1 + 2*x2 - x3;
      default: return x0;
    endcase
  endfunction

  task automatic prepare();
    for (int p = 0; p < 7; p++) begin
      for (int t = 0; t < PL; t++) begin
        longint s;
        s = 0;
        for (int i = 0; i < SEG; i++) begin
          if (t - i >= 0 && t - i < SEG) s += ev(1'b0, p, i) * ev(1'b1, p, t - i);
        end
        sp[p][t] = s & 64'hffff;
      end
    end
    for (int t = 0; t < OL; t++) begin
      longint s;
      s = 0;
      for (int i = 0; i < NC; i++) begin
        if (t - i >= 0 && t - i < NC) s += longint'(a[i]) * longint'(b[t - i]);
      end
      expv[t] = s;
    end
  endtask

  // Called at a falling edge.
  task automatic run_frame(input int gap, input int stall, input bit poke);
    string dreq;
    dreq = poke ? "R10" : (gap > 0 ? "R11" : "R4");
    prepare();
    for (int t = 0; t < PL; t++) begin
      if (gap > 0 && (t % 2) == 1) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      in_valid = 1'b1;
      for (int p = 0; p < 7; p++) begin
        in_data[p*WB +: WB] = WB'(sp[p][t]);
        in_data_b[p*WB_B +: WB_B] = WB_B'(sp[p][t]);
      end
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2", longint'(in_ready), 0);
    chk(out_valid == 1'b1, "R5", longint'(out_valid), 1);
    for (int idx = 0; idx < OL; idx++) begin
      if (stall > 0 && (idx % 3) == 0) begin
        logic [CB-1:0] held;
        logic held_last;
        out_ready = 1'b0;
        if (poke) begin
          in_valid = 1'b1;
          in_data = {4{$urandom()}};
          in_data_b = in_data[7*WB_B-1:0];
        end
        held = out_data;
        held_last = out_last;
        repeat (stall) @(negedge clk);
        chk(out_valid && out_data == held && out_last == held_last, "R6",
            longint'(out_data), longint'(held));
        in_valid = 1'b0;
      end
      out_ready = 1'b1;
      chk(out_valid == 1'b1, "R5", longint'(out_valid), 1);
      chk(longint'(out_data) == (expv[idx] & 64'h1fff), dreq,
          longint'(out_data), expv[idx] & 64'h1fff);
      chk(longint'(out_data_b) == (expv[idx] & 64'h3ff), "R9",
          longint'(out_data_b), expv[idx] & 64'h3ff);
      chk(out_last == (idx == OL - 1), "R7", longint'(out_last), longint'(idx == OL - 1));
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R8",
        longint'({in_ready, out_valid}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0;
    out_ready = 1'b0;
    in_data = '0;
    in_data_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    chk(out_last == 1'b0, "R1", longint'(out_last), 0);

    // R3 R4 all-zero operands
    for (int i = 0; i < NC; i++) begin a[i] = 0; b[i] = 0; end
    run_frame(0, 0, 1'b0);

    // R3 R4 all-maximum operands with stalls (R6)
    for (int i = 0; i < NC; i++) begin a[i] = 8191; b[i] = 8191; end
    run_frame(0, 2, 1'b0);

    // R4 R8 sweep over every pair of single-term operands, back to back
    for (int i = 0; i < NC; i++) begin
      for (int j = 0; j < NC; j++) begin
        for (int m = 0; m < NC; m++) begin a[m] = 0; b[m] = 0; end
        a[i] = 8191 - 37 * i;
        b[j] = 4096 + 123 * j;
        run_frame(0, 0, 1'b0);
      end
    end

    // R10 R11 dense random operands under varied handshake patterns
    for (int f = 0; f < 24; f++) begin
      for (int m = 0; m < NC; m++) begin
        a[m] = int'($urandom_range(0, 8191));
        b[m] = int'($urandom_range(0, 8191));
      end
      run_frame(f % 3, (f % 4 == 0) ? 0 : 1 + (f % 3), f[0]);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule